// File: doc/BRIEF.md
# PCI Interrupt Pin Router

This block takes the level-sensitive interrupt pins of a group of PCI device slots and merges them onto four shared request lines, A to D. Before the merge, each slot's pins are rotated by the slot number. This spreads the commonly used first pin of different devices across different lines. The four lines are then steered onto a 16-input legacy interrupt controller. Four byte-wide routing registers do the steering, one register per request line. Each register holds a target number and a route-disable flag.

Each controller input is driven by the OR of every enabled request line routed to it. Several lines may share one input, and their levels combine as a wired OR. A small byte-wide configuration port writes and reads back the routing registers. The controller outputs are registered, so any change on a pin or in a register reaches them one clock later.

The pin inputs and controller outputs are plain levels, not a stream. The configuration port is a single-cycle strobe with no back-pressure, so the block never stalls a write.

Top module: `pirq_router`

## Requirements
- R1: After reset, the routing registers for lines A, B, C and D read 0x0A, 0x0A, 0x0B and 0x0B, and all sixteen outputs are low.
- R2: Pin p (0..3 for A..D) of slot s arrives on `dev_pins[4*s+p]` and drives request line (p+s) mod 4.
- R3: A request line is high when any device pin mapped onto it, from any slot, is high.
- R4: Output t is the OR of every request line whose routing register has bits [3:0] equal to t and bit 7 clear. Bits 6:4 do not affect routing.
- R5: A routing register with bit 7 set contributes to no output, whatever its target bits hold.
- R6: A write with `cfg_wr_en` high to address 0x60, 0x61, 0x62 or 0x63 stores `cfg_wdata` into the register of line A, B, C or D respectively.
- R7: Reading a routing register returns the stored byte unchanged, bit 7 included. Any other address reads 0x00, and writes to any other address change no register.
- R8: Target values 0, 1, 2, 8 and 13 are reserved: a line routed to one of them drives no output, so those outputs stay low.
- R9: `irq_out` is registered. A pin or register change is visible at the outputs after exactly one rising clock edge, not before.
- R10: At most four outputs are high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_pins | input | 4*NUM_SLOTS | Device interrupt pin levels, four per slot |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for `cfg_addr` |
| irq_out | output | NUM_TARGETS | Levels towards the interrupt controller |

## Verification
The hardest case to reach from the ports is several request lines converging on one controller input. In that case the output must stay high until the last contributing line, fed from different slots through different rotations, drops. Uniform random pins rarely produce it. The stimulus therefore routes all four lines onto one target in a directed step. It then releases pins one slot at a time, and random phases draw sparse pin patterns while rewriting registers with random targets, reserved values and disable bits. A separate step writes to addresses just outside the register window and reads all four registers back to show that they are untouched.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int NUM_LINES  = 4;
  localparam int REG_W      = 8;
  localparam int DIS_BIT    = 7;
  localparam int SEL_W      = 4;
  localparam logic [7:0] ROUTE_BASE = 8'h60;

  typedef logic [REG_W-1:0] route_t;

  // reset routing per request line
  function automatic route_t route_default(input int line);
    return (line < 2) ? route_t'(8'h0A) : route_t'(8'h0B);
  endfunction

  // targets that never receive a request line
  function automatic logic tgt_reserved(input logic [SEL_W-1:0] t);
    return (t == 4'd0) || (t == 4'd1) || (t == 4'd2) ||
           (t == 4'd8) || (t == 4'd13);
  endfunction
endpackage

// File: rtl/pirq_swizzle.sv
module pirq_swizzle
  import pirq_pkg::*;
#(
  parameter int NUM_SLOTS = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [4*NUM_SLOTS-1:0]   pins,
  output logic [NUM_LINES-1:0]     lines
);
  localparam int PIN_W = 4 * NUM_SLOTS;

  always_comb begin
    lines = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      for (int p = 0; p < NUM_LINES; p++) begin
        lines[(p + s) % NUM_LINES] = lines[(p + s) % NUM_LINES] | pins[s*NUM_LINES + p];
      end
    end
  end

  // R3: activity on any pin shows on some line and vice versa
  a_r3_activity_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (|pins) == (|lines));

  // R2: slot 1 pin A lands on line B
  a_r2_slot1_rotates: assert property (@(posedge clk) disable iff (!rst_n)
    (PIN_W > 4 && pins[4 % PIN_W]) |-> lines[1]);
endmodule

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
  import pirq_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [7:0]                 addr,
  input  logic [7:0]                 wdata,
  output logic [7:0]                 rdata,
  output logic [NUM_LINES*REG_W-1:0] routes
);
  localparam int IDX_W = $clog2(NUM_LINES);

  logic             in_win;
  logic [IDX_W-1:0] idx;

  assign in_win = (addr[7:IDX_W] == ROUTE_BASE[7:IDX_W]);
  assign idx    = addr[IDX_W-1:0];

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_reg
    route_t q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   q <= route_default(l);
      else if (wr_en && in_win && idx == IDX_W'(l)) q <= wdata;
    end
    assign routes[l*REG_W +: REG_W] = q;

    // R6: a write to this line's offset lands next cycle
    a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == (ROUTE_BASE + 8'(l))) |=> (q == $past(wdata)));
  end

  always_comb begin
    rdata = '0;
    if (in_win) rdata = routes[idx*REG_W +: REG_W];
  end

  // R7: writes outside the window change nothing
  a_r7_outside_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (addr >= ROUTE_BASE) && (addr < ROUTE_BASE + 8'(NUM_LINES)))
      |=> $stable(routes));
endmodule

// File: rtl/pirq_fanout.sv
module pirq_fanout
  import pirq_pkg::*;
#(
  parameter int NUM_TARGETS = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_LINES-1:0]       lines,
  input  logic [NUM_LINES*REG_W-1:0] routes,
  output logic [NUM_TARGETS-1:0]     irq_q
);
  localparam int TGT_W = (NUM_TARGETS > 1) ? $clog2(NUM_TARGETS) : 1;

  logic [NUM_TARGETS-1:0] irq_d;
  logic [NUM_LINES-1:0]   route_on;

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_on
    assign route_on[l] = !routes[l*REG_W + DIS_BIT] &&
                         !tgt_reserved(routes[l*REG_W +: SEL_W]);
  end

  for (genvar t = 0; t < NUM_TARGETS; t++) begin : g_tgt
    always_comb begin
      irq_d[t] = 1'b0;
      for (int l = 0; l < NUM_LINES; l++) begin
        if (route_on[l] && routes[l*REG_W +: TGT_W] == TGT_W'(t))
          irq_d[t] = irq_d[t] | lines[l];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_d;
  end

  // R5: with every route disabled, nothing is asserted next cycle
  a_r5_all_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (routes[DIS_BIT] && routes[REG_W+DIS_BIT] && routes[2*REG_W+DIS_BIT] &&
     routes[3*REG_W+DIS_BIT]) |=> (irq_q == '0));
endmodule

// File: rtl/pirq_router.sv
module pirq_router
  import pirq_pkg::*;
#(
  parameter int NUM_SLOTS   = 8,
  parameter int NUM_TARGETS = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [4*NUM_SLOTS-1:0]   dev_pins,
  input  logic                     cfg_wr_en,
  input  logic [7:0]               cfg_addr,
  input  logic [7:0]               cfg_wdata,
  output logic [7:0]               cfg_rdata,
  output logic [NUM_TARGETS-1:0]   irq_out
);
  logic [NUM_LINES-1:0]       lines;
  logic [NUM_LINES*REG_W-1:0] routes;

  pirq_swizzle #(.NUM_SLOTS(NUM_SLOTS)) u_swz (
    .clk(clk), .rst_n(rst_n), .pins(dev_pins), .lines(lines));

  pirq_route_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .routes(routes));

  pirq_fanout #(.NUM_TARGETS(NUM_TARGETS)) u_fan (
    .clk(clk), .rst_n(rst_n), .lines(lines), .routes(routes), .irq_q(irq_out));

  // R10: four lines reach at most four outputs
  a_r10_max_four: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irq_out) <= NUM_LINES);

  // R8: reserved targets are never driven
  a_r8_reserved_low: assert property (@(posedge clk) disable iff (!rst_n)
    (NUM_TARGETS < 14) ||
    (irq_out[0] == 1'b0 && irq_out[1] == 1'b0 && irq_out[2] == 1'b0 &&
     irq_out[8 % NUM_TARGETS] == 1'b0 && irq_out[13 % NUM_TARGETS] == 1'b0));

  // R9: quiet pins for a cycle leave quiet outputs
  a_r9_quiet_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_pins == '0) |=> (irq_out == '0));
endmodule

// File: tb/tb_pirq_router.sv
module tb_pirq_router;
  localparam int NS = 8;
  localparam int NT = 16;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [4*NS-1:0] dev_pins = '0;
  logic          cfg_wr_en = 0;
  logic [7:0]    cfg_addr = '0;
  logic [7:0]    cfg_wdata = '0;
  logic [7:0]    cfg_rdata;
  logic [NT-1:0] irq_out;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_route [4];

  always #10 clk = ~clk;

  pirq_router #(.NUM_SLOTS(NS), .NUM_TARGETS(NT)) dut (
    .clk(clk), .rst_n(rst_n), .dev_pins(dev_pins), .cfg_wr_en(cfg_wr_en),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .irq_out(irq_out));

  function automatic logic reserved(input logic [3:0] t);
    return t == 0 || t == 1 || t == 2 || t == 8 || t == 13;
  endfunction

  function automatic logic [NT-1:0] expect_irq(input logic [4*NS-1:0] p);
    logic [3:0] ln = '0;
    logic [NT-1:0] o = '0;
    for (int s = 0; s < NS; s++)
      for (int k = 0; k < 4; k++)
        if (p[4*s+k]) ln[(k+s)%4] = 1'b1;
    for (int l = 0; l < 4; l++)
      if (!m_route[l][7] && !reserved(m_route[l][3:0]) && ln[l])
        o[m_route[l][3:0]] = 1'b1;
    return o;
  endfunction

  task automatic chk_irq(input string req);
    logic [NT-1:0] e = expect_irq(dev_pins);
    checks++;
    if (irq_out !== e) begin
      errors++;
      $display("FAIL %s irq_out=%h expected=%h", req, irq_out, e);
    end
  endtask

  task automatic chk_val(input string req, input logic [NT-1:0] act, input logic [NT-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_wr_en = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 0;
    if (a >= 8'h60 && a <= 8'h63) m_route[a[1:0]] = d;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    cfg_addr = a;
    #1;
    chk_val(req, NT'(cfg_rdata), NT'(exp));
  endtask

  task automatic set_pins(input logic [4*NS-1:0] p);
    @(negedge clk);
    dev_pins = p;
    @(negedge clk);
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  bit done = 0;
  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4242));
    m_route[0] = 8'h0A; m_route[1] = 8'h0A; m_route[2] = 8'h0B; m_route[3] = 8'h0B;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk_val("R1 irq after reset", irq_out, '0);
    rd_chk("R1 reg A", 8'h60, 8'h0A);
    rd_chk("R1 reg B", 8'h61, 8'h0A);
    rd_chk("R1 reg C", 8'h62, 8'h0B);
    rd_chk("R1 reg D", 8'h63, 8'h0B);

    // R2 rotation: slot 2 pin A -> line C -> target 11
    set_pins(32'h1 << 8);
    chk_val("R2 slot2 pinA", irq_out, 16'h0800);
    // slot 3 pin B -> line A -> target 10
    set_pins(32'h2 << 12);
    chk_val("R2 slot3 pinB", irq_out, 16'h0400);

    // R9 latency: change visible only after one edge
    @(negedge clk);
    dev_pins = 32'h1 << 8;
    #1;
    chk_val("R9 before edge", irq_out, 16'h0400);
    @(negedge clk);
    chk_val("R9 after edge", irq_out, 16'h0800);

    // R6/R4 distinct targets per line
    wr(8'h60, 8'h03); wr(8'h61, 8'h04); wr(8'h62, 8'h05); wr(8'h63, 8'h06);
    settle();
    rd_chk("R6 reg C readback", 8'h62, 8'h05);
    set_pins(32'h0000_000F);
    chk_val("R4 four targets", irq_out, 16'h0078);
    chk_irq("R2 slot0 all pins");

    // R3 sharing: all lines to one target; release slot by slot
    wr(8'h60, 8'h09); wr(8'h61, 8'h09); wr(8'h62, 8'h09); wr(8'h63, 8'h09);
    set_pins(32'h0000_2418);      // slot0 pinD, slot1 pinA, slot2 pinC, slot3 pinB
    chk_val("R3 shared high", irq_out, 16'h0200);
    set_pins(32'h0000_2410);
    chk_val("R3 still high one source", irq_out, 16'h0200);
    set_pins(32'h0);
    chk_val("R3 all released", irq_out, 16'h0000);

    // R5 disable bit, R7 readback keeps bit 7 and 6:4
    wr(8'h60, 8'hF9);
    set_pins(32'h1);
    chk_val("R5 disabled route", irq_out, 16'h0000);
    rd_chk("R7 readback bit7", 8'h60, 8'hF9);
    wr(8'h60, 8'h79);
    settle();
    chk_val("R4 bits 6:4 ignored", irq_out, 16'h0200);

    // R8 reserved targets
    wr(8'h60, 8'h08); wr(8'h61, 8'h0D); wr(8'h62, 8'h00); wr(8'h63, 8'h02);
    set_pins(32'h0000_000F);
    chk_val("R8 reserved quiet", irq_out, 16'h0000);

    // R7 out-of-window writes ignored, reads zero
    wr(8'h5F, 8'hAA); wr(8'h64, 8'h55); wr(8'hE0, 8'h33);
    rd_chk("R7 reg A untouched", 8'h60, 8'h08);
    rd_chk("R7 reg B untouched", 8'h61, 8'h0D);
    rd_chk("R7 reg C untouched", 8'h62, 8'h00);
    rd_chk("R7 reg D untouched", 8'h63, 8'h02);
    rd_chk("R7 outside reads zero", 8'h64, 8'h00);
    rd_chk("R7 below reads zero", 8'h5F, 8'h00);

    // random phase
    for (int i = 0; i < 400; i++) begin
      if (($urandom % 3) == 0) begin
        logic [7:0] a = 8'h5E + 8'($urandom % 8);
        wr(a, 8'($urandom));
      end
      set_pins($urandom & $urandom & $urandom);
      chk_irq("R4 random");
      chk_val("R10 at most four", NT'($countones(irq_out) <= 4), NT'(1));
      if ((i % 25) == 0) begin
        for (int l = 0; l < 4; l++) rd_chk("R7 random readback", 8'h60 + 8'(l), m_route[l]);
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule